// File: doc/BRIEF.md
# Dual Mailbox Bypass Registers

This block carries short messages around a pair of FIFOs. Mailbox 1 takes a word written on port A (clock `clk_a`) and presents it to the port B side (clock `clk_b`). Mailbox 2 takes a word written on port C (clock `clk_c`) and presents it to the port A side. Each mailbox holds one word. Its active-low full flag falls on the writer's clock edge that stores the word. It rises again once the reader has taken the word and that event has reached the writer's clock domain. The three clocks may be unrelated or may be the same clock.

Each transfer follows valid/ready rules. On the write side, a write is offered when its strobes are active, and the full flag being high acts as ready. A write offered while the flag is low is dropped, and the writer must offer it again later. On the read side, the reader-domain valid output shows that a word is waiting. The word is consumed on the reader's edge where the read is selected with the mailbox select high. A read selected while valid is low changes nothing. Set and take events cross between domains as toggles through a chain of `SYNC_STAGES` flops. With the default of 2 and a shared clock, each crossing takes exactly two edges. With unrelated clocks it takes at most three edges of the receiving clock.

The block also contains the port A output multiplexer. This multiplexer returns either the mailbox 2 word or the FIFO2 output register on the port A data bus. It drives `a_oe` so that the pad cell can float the bus.

Top module: `mailbox_bypass`

## Requirements
- R1: On a `clk_a` edge where `a_cs_n`=0, `a_wr_rd`=1, `a_en`=1, `a_mbox`=1 and `mbf1_n`=1, mailbox 1 stores `a_din` and `mbf1_n` is 0 after that edge.
- R2: On a `clk_c` edge where `c_wen`=1, `c_mbox`=1 and `mbf2_n`=1, mailbox 2 stores `c_din` and `mbf2_n` is 0 after that edge.
- R3: A write offered while the mailbox's full flag is 0 is dropped, and the stored word seen on `b_mail` (mailbox 1) or on `a_dout` (mailbox 2) is unchanged.
- R4: After an accepted write, the reader-domain valid (`mail1_valid` on `clk_b`, `mail2_valid` on `clk_a`) rises `SYNC_STAGES` reader edges later when the clocks are shared, and within `SYNC_STAGES`+1 edges when they are not. It then stays high with the word stable until it is taken.
- R5: A take (mailbox 1: `b_ren`=1 and `b_mbox`=1; mailbox 2: `a_cs_n`=0, `a_wr_rd`=0, `a_en`=1, `a_mbox`=1) on an edge with valid high clears valid after that edge. The writer's full flag returns to 1 `SYNC_STAGES` writer edges later. A read with the mailbox select low does not take.
- R6: A take requested while valid is 0 has no effect: the flags stay unchanged, and the next write completes normally.
- R7: `a_oe` is 1 exactly when `a_cs_n`=0 and `a_wr_rd`=0. While `a_oe` is 0, `a_dout` is all zeros.
- R8: While `a_oe` is 1, `a_dout` shows the mailbox 2 word when `a_mbox`=1 and `fifo2_q` when `a_mbox`=0.
- R9: A low level on `mrst1_n` or `prst1_n` empties mailbox 1: `mbf1_n`=1, `mail1_valid`=0 and the stored word is zero. `mrst2_n` and `prst2_n` do the same for mailbox 2. Neither reset disturbs the other mailbox.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| clk_c | input | 1 | Port C clock |
| mrst1_n | input | 1 | FIFO1 master reset, active low, asynchronous |
| prst1_n | input | 1 | FIFO1 partial reset, active low, asynchronous |
| mrst2_n | input | 1 | FIFO2 master reset, active low, asynchronous |
| prst2_n | input | 1 | FIFO2 partial reset, active low, asynchronous |
| a_cs_n | input | 1 | Port A chip select, active low |
| a_wr_rd | input | 1 | Port A direction: 1 write, 0 read |
| a_en | input | 1 | Port A transfer enable |
| a_mbox | input | 1 | Port A mailbox select |
| a_din | input | DATA_W | Port A write data |
| fifo2_q | input | DATA_W | FIFO2 output register contents |
| a_oe | output | 1 | Port A bus drive enable |
| a_dout | output | DATA_W | Port A read data |
| mbf1_n | output | 1 | Mailbox 1 full flag, active low, `clk_a` domain |
| mail2_valid | output | 1 | Mailbox 2 word waiting, `clk_a` domain |
| b_ren | input | 1 | Port B read enable |
| b_mbox | input | 1 | Port B mailbox select |
| mail1_valid | output | 1 | Mailbox 1 word waiting, `clk_b` domain |
| b_mail | output | DATA_W | Mailbox 1 word, whole width |
| c_wen | input | 1 | Port C write enable |
| c_mbox | input | 1 | Port C mailbox select |
| c_din | input | DATA_W | Port C write data |
| mbf2_n | output | 1 | Mailbox 2 full flag, active low, `clk_c` domain |

## Verification
The checker verifies the following on every clock:
- an accepted write lowers its flag on the next edge;
- the stored word cannot change while the flag is low or while valid waits untaken;
- a take drops valid at once;
- the port A bus is quiet when not driven and passes `fifo2_q` when the mailbox select is low.

Other properties depend on sequences over several edges and are covered only by the bench's scenarios against its reference model. These include:
- the exact crossing delay of set and take events;
- the return of the full flag after a take;
- a take of an empty mailbox leaving no trace on later writes;
- one mailbox's reset leaving the other intact.

// File: rtl/mailbox_pkg.sv
package mailbox_pkg;
  localparam int unsigned DEF_DATA_W = 36;
  localparam int unsigned DEF_SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    PA_IDLE  = 2'd0,
    PA_WRITE = 2'd1,
    PA_READ  = 2'd2
  } pa_op_e;

  function automatic pa_op_e pa_decode(input logic cs_n, input logic wr_rd, input logic en);
    if (cs_n || !en) return PA_IDLE;
    return wr_rd ? PA_WRITE : PA_READ;
  endfunction
endpackage

// File: rtl/mbox_toggle_sync.sv
module mbox_toggle_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tgl_in,
  output logic tgl_out
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= tgl_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], tgl_in};
      end
    end
  endgenerate

  assign tgl_out = chain_q[LAST];
endmodule

// File: rtl/mbox_channel.sv
module mbox_channel #(
  parameter int unsigned DATA_W      = 36,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_w,
  input  logic              clk_r,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  input  logic              rd_take,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  logic              set_tgl_q;
  logic              clr_tgl_q;
  logic              set_seen_r;
  logic              clr_seen_w;
  logic [DATA_W-1:0] word_q;
  logic              full_w;
  logic              accept_w;
  logic              take_r;

  // writer view: full from own set toggle until the take toggle arrives
  assign full_w   = set_tgl_q ^ clr_seen_w;
  assign wr_ready = ~full_w;
  assign accept_w = wr_valid & ~full_w;

  // reader view: valid once the set toggle arrives, until taken locally
  assign rd_valid = set_seen_r ^ clr_tgl_q;
  assign take_r   = rd_take & rd_valid;
  assign rd_data  = word_q;

  always_ff @(posedge clk_w or negedge rst_n) begin
    if (!rst_n) begin
      set_tgl_q <= 1'b0;
      word_q    <= '0;
    end else if (accept_w) begin
      set_tgl_q <= ~set_tgl_q;
      word_q    <= wr_data;
    end
  end

  always_ff @(posedge clk_r or negedge rst_n) begin
    if (!rst_n)      clr_tgl_q <= 1'b0;
    else if (take_r) clr_tgl_q <= ~clr_tgl_q;
  end

  mbox_toggle_sync #(.STAGES(SYNC_STAGES)) u_set_to_r (
    .clk    (clk_r),
    .rst_n  (rst_n),
    .tgl_in (set_tgl_q),
    .tgl_out(set_seen_r)
  );

  mbox_toggle_sync #(.STAGES(SYNC_STAGES)) u_clr_to_w (
    .clk    (clk_w),
    .rst_n  (rst_n),
    .tgl_in (clr_tgl_q),
    .tgl_out(clr_seen_w)
  );
endmodule

// File: rtl/mailbox_bypass.sv
module mailbox_bypass
  import mailbox_pkg::*;
#(
  parameter int unsigned DATA_W      = DEF_DATA_W,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic              clk_a,
  input  logic              clk_b,
  input  logic              clk_c,
  input  logic              mrst1_n,
  input  logic              prst1_n,
  input  logic              mrst2_n,
  input  logic              prst2_n,
  input  logic              a_cs_n,
  input  logic              a_wr_rd,
  input  logic              a_en,
  input  logic              a_mbox,
  input  logic [DATA_W-1:0] a_din,
  input  logic [DATA_W-1:0] fifo2_q,
  output logic              a_oe,
  output logic [DATA_W-1:0] a_dout,
  output logic              mbf1_n,
  output logic              mail2_valid,
  input  logic              b_ren,
  input  logic              b_mbox,
  output logic              mail1_valid,
  output logic [DATA_W-1:0] b_mail,
  input  logic              c_wen,
  input  logic              c_mbox,
  input  logic [DATA_W-1:0] c_din,
  output logic              mbf2_n
);
  pa_op_e            pa_op;
  logic              box1_rst_n;
  logic              box2_rst_n;
  logic              box1_wr;
  logic              box1_take;
  logic              box2_wr;
  logic              box2_take;
  logic [DATA_W-1:0] box2_word;

  // either reset of a FIFO empties its mailbox
  assign box1_rst_n = mrst1_n & prst1_n;
  assign box2_rst_n = mrst2_n & prst2_n;

  assign pa_op     = pa_decode(a_cs_n, a_wr_rd, a_en);
  assign box1_wr   = (pa_op == PA_WRITE) && a_mbox;
  assign box2_take = (pa_op == PA_READ) && a_mbox;
  assign box1_take = b_ren & b_mbox;
  assign box2_wr   = c_wen & c_mbox;

  mbox_channel #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_box1 (
    .clk_w   (clk_a),
    .clk_r   (clk_b),
    .rst_n   (box1_rst_n),
    .wr_valid(box1_wr),
    .wr_data (a_din),
    .wr_ready(mbf1_n),
    .rd_take (box1_take),
    .rd_valid(mail1_valid),
    .rd_data (b_mail)
  );

  mbox_channel #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_box2 (
    .clk_w   (clk_c),
    .clk_r   (clk_a),
    .rst_n   (box2_rst_n),
    .wr_valid(box2_wr),
    .wr_data (c_din),
    .wr_ready(mbf2_n),
    .rd_take (box2_take),
    .rd_valid(mail2_valid),
    .rd_data (box2_word)
  );

  // port A return path: bus driven only for a selected read direction
  always_comb begin
    a_oe   = ~a_cs_n & ~a_wr_rd;
    a_dout = '0;
    if (a_oe) a_dout = a_mbox ? box2_word : fifo2_q;
  end
endmodule

// File: rtl/mailbox_bypass_props.sv
module mailbox_bypass_props #(
  parameter int unsigned DATA_W = 36
) (
  input logic              clk_a,
  input logic              clk_b,
  input logic              clk_c,
  input logic              mrst1_n,
  input logic              prst1_n,
  input logic              mrst2_n,
  input logic              prst2_n,
  input logic              a_cs_n,
  input logic              a_wr_rd,
  input logic              a_en,
  input logic              a_mbox,
  input logic [DATA_W-1:0] fifo2_q,
  input logic              a_oe,
  input logic [DATA_W-1:0] a_dout,
  input logic              mbf1_n,
  input logic              mail2_valid,
  input logic              b_ren,
  input logic              b_mbox,
  input logic              mail1_valid,
  input logic [DATA_W-1:0] b_mail,
  input logic              c_wen,
  input logic              c_mbox,
  input logic              mbf2_n
);
  a_r1_write_lowers_flag: assert property (@(posedge clk_a) disable iff (!(mrst1_n && prst1_n))
    (!a_cs_n && a_wr_rd && a_en && a_mbox && mbf1_n) |=> !mbf1_n);

  a_r2_write_lowers_flag: assert property (@(posedge clk_c) disable iff (!(mrst2_n && prst2_n))
    (c_wen && c_mbox && mbf2_n) |=> !mbf2_n);

  a_r3_word_held_while_full: assert property (@(posedge clk_a) disable iff (!(mrst1_n && prst1_n))
    !mbf1_n |=> $stable(b_mail));

  a_r4_valid_waits: assert property (@(posedge clk_b) disable iff (!(mrst1_n && prst1_n))
    (mail1_valid && !(b_ren && b_mbox)) |=> (mail1_valid && $stable(b_mail)));

  a_r5_portb_take_clears: assert property (@(posedge clk_b) disable iff (!(mrst1_n && prst1_n))
    (b_ren && b_mbox && mail1_valid) |=> !mail1_valid);

  a_r5_porta_take_clears: assert property (@(posedge clk_a) disable iff (!(mrst2_n && prst2_n))
    (!a_cs_n && !a_wr_rd && a_en && a_mbox && mail2_valid) |=> !mail2_valid);

  a_r7_quiet_bus: assert property (@(posedge clk_a) disable iff (!(mrst2_n && prst2_n))
    !a_oe |-> (a_dout == '0));

  a_r8_fifo_path: assert property (@(posedge clk_a) disable iff (!(mrst2_n && prst2_n))
    (a_oe && !a_mbox) |-> (a_dout == fifo2_q));
endmodule

bind mailbox_bypass mailbox_bypass_props #(.DATA_W(DATA_W)) u_props (
  .clk_a      (clk_a),
  .clk_b      (clk_b),
  .clk_c      (clk_c),
  .mrst1_n    (mrst1_n),
  .prst1_n    (prst1_n),
  .mrst2_n    (mrst2_n),
  .prst2_n    (prst2_n),
  .a_cs_n     (a_cs_n),
  .a_wr_rd    (a_wr_rd),
  .a_en       (a_en),
  .a_mbox     (a_mbox),
  .fifo2_q    (fifo2_q),
  .a_oe       (a_oe),
  .a_dout     (a_dout),
  .mbf1_n     (mbf1_n),
  .mail2_valid(mail2_valid),
  .b_ren      (b_ren),
  .b_mbox     (b_mbox),
  .mail1_valid(mail1_valid),
  .b_mail     (b_mail),
  .c_wen      (c_wen),
  .c_mbox     (c_mbox),
  .mbf2_n     (mbf2_n)
);

// File: tb/mailbox_bypass_test.sv
`timescale 1ns/1ps
module mailbox_bypass_test;
  localparam int W = 36;
  localparam int LAT = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         mrst1_n = 1'b1, prst1_n = 1'b1, mrst2_n = 1'b1, prst2_n = 1'b1;
  logic         a_cs_n = 1'b1, a_wr_rd = 1'b0, a_en = 1'b0, a_mbox = 1'b0;
  logic [W-1:0] a_din = '0, fifo2_q = '0, c_din = '0;
  logic         b_ren = 1'b0, b_mbox = 1'b0, c_wen = 1'b0, c_mbox = 1'b0;
  logic         a_oe, mbf1_n, mail2_valid, mail1_valid, mbf2_n;
  logic [W-1:0] a_dout, b_mail;

  mailbox_bypass uut (
    .clk_a(clk), .clk_b(clk), .clk_c(clk),
    .mrst1_n(mrst1_n), .prst1_n(prst1_n), .mrst2_n(mrst2_n), .prst2_n(prst2_n),
    .a_cs_n(a_cs_n), .a_wr_rd(a_wr_rd), .a_en(a_en), .a_mbox(a_mbox),
    .a_din(a_din), .fifo2_q(fifo2_q), .a_oe(a_oe), .a_dout(a_dout),
    .mbf1_n(mbf1_n), .mail2_valid(mail2_valid),
    .b_ren(b_ren), .b_mbox(b_mbox), .mail1_valid(mail1_valid), .b_mail(b_mail),
    .c_wen(c_wen), .c_mbox(c_mbox), .c_din(c_din), .mbf2_n(mbf2_n)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: flags, pending crossing countdowns, words
  bit           m1_full, m1_avail, m2_full, m2_avail;
  int           m1_set_cd, m1_clr_cd, m2_set_cd, m2_clr_cd;
  logic [W-1:0] m1_word, m2_word;

  always @(posedge clk) begin
    bit acc1, tk1, acc2, tk2;
    acc1 = !a_cs_n && a_wr_rd && a_en && a_mbox && !m1_full;
    tk1  = b_ren && b_mbox && m1_avail;
    acc2 = c_wen && c_mbox && !m2_full;
    tk2  = !a_cs_n && !a_wr_rd && a_en && a_mbox && m2_avail;
    if (!(mrst1_n && prst1_n)) begin
      m1_full = 0; m1_avail = 0; m1_set_cd = 0; m1_clr_cd = 0; m1_word = '0;
    end else begin
      if (m1_set_cd > 0) begin m1_set_cd--; if (m1_set_cd == 0) m1_avail = 1; end
      if (m1_clr_cd > 0) begin m1_clr_cd--; if (m1_clr_cd == 0) m1_full = 0; end
      if (acc1) begin m1_full = 1; m1_word = a_din; m1_set_cd = LAT; end
      if (tk1)  begin m1_avail = 0; m1_clr_cd = LAT; end
    end
    if (!(mrst2_n && prst2_n)) begin
      m2_full = 0; m2_avail = 0; m2_set_cd = 0; m2_clr_cd = 0; m2_word = '0;
    end else begin
      if (m2_set_cd > 0) begin m2_set_cd--; if (m2_set_cd == 0) m2_avail = 1; end
      if (m2_clr_cd > 0) begin m2_clr_cd--; if (m2_clr_cd == 0) m2_full = 0; end
      if (acc2) begin m2_full = 1; m2_word = c_din; m2_set_cd = LAT; end
      if (tk2)  begin m2_avail = 0; m2_clr_cd = LAT; end
    end
    #1;
    if (!done) begin
      logic         exp_oe;
      logic [W-1:0] exp_dout;
      exp_oe   = !a_cs_n && !a_wr_rd;
      exp_dout = exp_oe ? (a_mbox ? m2_word : fifo2_q) : '0;
      check(mbf1_n == !m1_full, "R1/R5 mbf1_n", W'(mbf1_n), W'(!m1_full));
      check(mbf2_n == !m2_full, "R2/R5 mbf2_n", W'(mbf2_n), W'(!m2_full));
      check(mail1_valid == m1_avail, "R4 mail1_valid", W'(mail1_valid), W'(m1_avail));
      check(mail2_valid == m2_avail, "R4 mail2_valid", W'(mail2_valid), W'(m2_avail));
      check(b_mail == m1_word, "R3 b_mail", b_mail, m1_word);
      check(a_oe == exp_oe, "R7 a_oe", W'(a_oe), W'(exp_oe));
      check(a_dout == exp_dout, "R8 a_dout", a_dout, exp_dout);
    end
  end

  task automatic idle();
    a_cs_n = 1'b1; a_wr_rd = 1'b0; a_en = 1'b0; a_mbox = 1'b0;
    b_ren = 1'b0; b_mbox = 1'b0; c_wen = 1'b0; c_mbox = 1'b0;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1;
    mrst1_n = 1'b0; mrst2_n = 1'b0;
    tick(4);
    // R9: reset state
    check(mbf1_n == 1'b1 && mbf2_n == 1'b1, "R9 flags after reset", W'({mbf1_n, mbf2_n}), W'(2'b11));
    check(!mail1_valid && !mail2_valid && b_mail == '0, "R9 empty after reset", b_mail, '0);
    mrst1_n = 1'b1; mrst2_n = 1'b1;
    tick(2);

    // R1/R3: write mail1, then further writes while full are dropped
    a_cs_n = 1'b0; a_wr_rd = 1'b1; a_en = 1'b1; a_mbox = 1'b1; a_din = 36'h1_2345_6789;
    tick(1);
    a_din = 36'hF_0000_000F;
    tick(3);
    idle();
    tick(2);
    check(b_mail == 36'h1_2345_6789, "R3 write while full dropped", b_mail, 36'h1_2345_6789);
    // R5: read with select low does not take
    b_ren = 1'b1; b_mbox = 1'b0;
    tick(2);
    check(mail1_valid == 1'b1, "R5 select-low read ignored", W'(mail1_valid), W'(1));
    b_mbox = 1'b1;
    tick(1);
    idle();
    tick(3);
    check(mbf1_n == 1'b1, "R5 flag back after take", W'(mbf1_n), W'(1));
    // R6: takes of an empty mailbox leave no trace
    b_ren = 1'b1; b_mbox = 1'b1;
    tick(3);
    idle();
    check(mbf1_n == 1'b1 && !mail1_valid, "R6 empty take no effect", W'({mbf1_n, mail1_valid}), W'(2'b10));
    a_cs_n = 1'b0; a_wr_rd = 1'b1; a_en = 1'b1; a_mbox = 1'b1; a_din = 36'hA_BCDE_0123;
    tick(1);
    idle();
    tick(3);
    check(mail1_valid == 1'b1 && b_mail == 36'hA_BCDE_0123, "R6 next write completes", b_mail, 36'hA_BCDE_0123);

    // R2/R8: mail2 via port C, read back on port A; FIFO path with select low
    c_wen = 1'b1; c_mbox = 1'b1; c_din = 36'h5_5AA5_3C3C;
    tick(1);
    c_din = 36'h0_DEAD_BEEF;
    tick(1);
    idle();
    fifo2_q = 36'h7_7777_1111;
    a_cs_n = 1'b0; a_wr_rd = 1'b0; a_en = 1'b0; a_mbox = 1'b1;
    tick(2);
    check(a_dout == 36'h5_5AA5_3C3C, "R8 mailbox path", a_dout, 36'h5_5AA5_3C3C);
    a_mbox = 1'b0;
    tick(1);
    check(a_dout == 36'h7_7777_1111, "R8 fifo path", a_dout, 36'h7_7777_1111);
    a_cs_n = 1'b1;
    tick(1);
    check(!a_oe && a_dout == '0, "R7 bus quiet", a_dout, '0);

    // R9: partial reset of FIFO1 leaves mailbox 2 intact
    check(mail2_valid == 1'b1, "R9 mail2 waiting before reset", W'(mail2_valid), W'(1));
    prst1_n = 1'b0;
    tick(2);
    prst1_n = 1'b1;
    tick(1);
    check(mbf1_n && !mail1_valid && b_mail == '0, "R9 mailbox1 cleared", b_mail, '0);
    check(mail2_valid && !mbf2_n, "R9 mailbox2 untouched", W'({mail2_valid, mbf2_n}), W'(2'b10));
    mrst2_n = 1'b0;
    tick(2);
    mrst2_n = 1'b1;
    tick(1);
    check(mbf2_n && !mail2_valid, "R9 mailbox2 cleared", W'({mbf2_n, mail2_valid}), W'(2'b10));

    // mixed traffic against the per-clock model
    for (int i = 0; i < 600; i++) begin
      a_cs_n  = ($urandom % 4) == 0;
      a_wr_rd = $urandom % 2;
      a_en    = ($urandom % 3) != 0;
      a_mbox  = ($urandom % 3) != 0;
      a_din   = {$urandom, $urandom} & {W{1'b1}};
      fifo2_q = {$urandom, $urandom} & {W{1'b1}};
      b_ren   = ($urandom % 3) == 0;
      b_mbox  = ($urandom % 2) == 0;
      c_wen   = ($urandom % 3) == 0;
      c_mbox  = ($urandom % 2) == 0;
      c_din   = {$urandom, $urandom} & {W{1'b1}};
      prst2_n = ($urandom % 97) != 0;
      tick(1);
    end
    prst2_n = 1'b1;
    idle();
    tick(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    done = 1;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule